// File: doc/BRIEF.md
# Composite Sync Field and Weave Row Tracker

This block watches a composite sync stream from a 50/60 Hz video source, one sample per pixel enable, and derives the line and field timing a capture path needs. It finds line starts on a selectable sync edge and counts pixels within each line. It recognises the long pulses of the vertical interval. It tells even fields from odd fields by where the first long pulse falls within the line. From the parity history it decides whether the source is interlaced or progressive.

Downstream logic writes pixels into a double-height weave buffer. The block supplies the row to write for the current line. When the source is interlaced, a field writes only its own row set, even rows or odd rows, and the other set keeps the previous field's content. When the source is progressive, rows are written one after another. The block also provides a pixel strobe that is held off for a few pixels after each line start, which hides the glitchy samples around the sync edge. The sync input is taken to be synchronous to the clock.

Top module: `csync_weave_tracker`

## Requirements
- R1: `line_start_o` is high in a cycle where `pix_en_i` is high, the selected sync edge occurs on `csync_i`, and the pixel count is at least three quarters of `LINE_LEN`. With `edge_sel_i`=0 the selected edge is high-to-low; with `edge_sel_i`=1 it is low-to-high. An edge at half a line after a line start is not a line start.
- R2: `pix_cnt_o` is 1 in the cycle after a line start. It then rises by one for each cycle with `pix_en_i` high and holds while `pix_en_i` is low.
- R3: `pix_strobe_o` is low in the line-start cycle and for the next `MASK_PIX` pixel enables. Otherwise it equals `pix_en_i`.
- R4: A low pulse lasting at least `BROAD_MIN` pixel enables is a vertical pulse. When the first such pulse of a vertical interval ends, `field_start_o` pulses for one cycle, in the cycle after the pulse's rising edge. Later long pulses before the next short pulse raise no further field start.
- R5: At a field start, `field_odd_o` becomes 1 if the falling edge of that long pulse lay at least `LINE_LEN`/4 and less than 3·`LINE_LEN`/4 pixels after the last line start. Otherwise it becomes 0.
- R6: At a field start, `interlaced_o` becomes 1 if the new parity differs from the previous field's parity, and becomes 0 if it is the same. The first field after reset leaves `interlaced_o` unchanged.
- R7: At a field start, `row_addr_o` is loaded with the new parity if the source is interlaced, and with 0 if it is progressive. Each later line start, after the vertical interval has ended, adds 2 when interlaced and 1 when progressive.
- R8: During reset and right after it, `field_odd_o`, `interlaced_o`, `field_start_o`, `row_addr_o` and `pix_cnt_o` are 0, and `pix_strobe_o` follows `pix_en_i` while the sync input stays high.
- R9: `field_odd_o` and `interlaced_o` change only in a cycle where `field_start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel enable, one per pixel period |
| csync_i | input | 1 | Composite sync, active low |
| edge_sel_i | input | 1 | 0: time lines from the falling edge, 1: from the rising edge |
| line_start_o | output | 1 | Line start pulse |
| pix_cnt_o | output | CNT_W | Pixel enables since the last line start |
| pix_strobe_o | output | 1 | Gated pixel strobe |
| field_start_o | output | 1 | One-cycle pulse at the start of each field |
| field_odd_o | output | 1 | Parity of the current field |
| interlaced_o | output | 1 | Source classified as interlaced |
| row_addr_o | output | ROW_W | Weave buffer row for the current line |

## Verification
A wrong parity decision shows on `field_odd_o` one cycle after the long pulse ends. It then shows on the interlace flag and on the low bit of every row in that field. A row counter with the wrong step or the wrong start value is visible at the second line after the vertical interval. A gate counter that is off by one changes the number of suppressed strobes in every line, so it is seen within the first line. A wrong edge choice moves each line start by the width of the sync pulse.

// File: rtl/csync_pkg.sv
package csync_pkg;
  // parity decision: offset in the middle half of a line means odd field
  function automatic logic half_line_ofs(input int unsigned pos, input int unsigned len);
    return (pos >= len / 4) && (pos < len - len / 4);
  endfunction
endpackage

// File: rtl/cs_sync_edge.sv
module cs_sync_edge #(
  parameter int unsigned BROAD_MIN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_en_i,
  input  logic csync_i,
  input  logic edge_sel_i,
  output logic fall_o,
  output logic act_o,
  output logic broad_o,
  output logic narrow_o
);
  localparam int unsigned WW = $clog2(BROAD_MIN + 1) + 1;
  localparam logic [WW-1:0] WMAX = '1;

  logic          prev_q;
  logic [WW-1:0] low_q;
  logic          rise;

  assign fall_o   = pix_en_i & prev_q & ~csync_i;
  assign rise     = pix_en_i & ~prev_q & csync_i;
  assign act_o    = edge_sel_i ? rise : fall_o;
  assign broad_o  = rise & (low_q >= WW'(BROAD_MIN));
  assign narrow_o = rise & (low_q < WW'(BROAD_MIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      low_q  <= '0;
    end else if (pix_en_i) begin
      prev_q <= csync_i;
      if (csync_i)           low_q <= '0;
      else if (low_q != WMAX) low_q <= low_q + 1'b1;
    end
  end
endmodule

// File: rtl/cs_line_timer.sv
module cs_line_timer #(
  parameter int unsigned LINE_LEN = 454,
  parameter int unsigned MASK_PIX = 2,
  parameter int unsigned CNT_W    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic             act_i,
  input  logic             fall_i,
  output logic             line_start_o,
  output logic [CNT_W-1:0] pix_cnt_o,
  output logic [CNT_W-1:0] fall_pos_o,
  output logic             strobe_o
);
  localparam int unsigned LINE_MIN = (LINE_LEN * 3) / 4;
  localparam int unsigned MW = $clog2(MASK_PIX + 1) + 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [MW-1:0]    mask_q;

  assign line_start_o = act_i & (cnt_q >= CNT_W'(LINE_MIN));
  assign pix_cnt_o    = cnt_q;
  assign strobe_o     = pix_en_i & ~line_start_o & (mask_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      mask_q     <= '0;
      fall_pos_o <= '0;
    end else if (pix_en_i) begin
      if (line_start_o)      cnt_q <= CNT_W'(1);
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      if (line_start_o)        mask_q <= MW'(MASK_PIX);
      else if (mask_q != '0)   mask_q <= mask_q - 1'b1;
      if (fall_i) fall_pos_o <= line_start_o ? '0 : cnt_q;
    end
  end
endmodule

// File: rtl/cs_field_track.sv
module cs_field_track
  import csync_pkg::*;
#(
  parameter int unsigned LINE_LEN = 454,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned ROW_W    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             broad_i,
  input  logic             narrow_i,
  input  logic             line_start_i,
  input  logic [CNT_W-1:0] fall_pos_i,
  output logic             field_start_o,
  output logic             field_odd_o,
  output logic             interlaced_o,
  output logic [ROW_W-1:0] row_o
);
  logic in_vs_q, seen_q;
  logic new_odd, new_int, fld_evt;

  assign fld_evt = broad_i & ~in_vs_q;
  assign new_odd = half_line_ofs(int'(fall_pos_i), LINE_LEN);
  assign new_int = seen_q ? (new_odd != field_odd_o) : interlaced_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_vs_q       <= 1'b0;
      seen_q        <= 1'b0;
      field_start_o <= 1'b0;
      field_odd_o   <= 1'b0;
      interlaced_o  <= 1'b0;
      row_o         <= '0;
    end else begin
      field_start_o <= fld_evt;
      if (fld_evt) begin
        in_vs_q      <= 1'b1;
        seen_q       <= 1'b1;
        field_odd_o  <= new_odd;
        interlaced_o <= new_int;
        row_o        <= new_int ? ROW_W'(new_odd) : '0;
      end else begin
        if (narrow_i) in_vs_q <= 1'b0;
        if (line_start_i && !in_vs_q)
          row_o <= row_o + (interlaced_o ? ROW_W'(2) : ROW_W'(1));
      end
    end
  end
endmodule

// File: rtl/csync_weave_tracker.sv
module csync_weave_tracker #(
  parameter int unsigned LINE_LEN  = 454,
  parameter int unsigned BROAD_MIN = 64,
  parameter int unsigned MASK_PIX  = 2,
  parameter int unsigned ROW_W     = 10,
  localparam int unsigned CNT_W    = $clog2(2 * LINE_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic             csync_i,
  input  logic             edge_sel_i,
  output logic             line_start_o,
  output logic [CNT_W-1:0] pix_cnt_o,
  output logic             pix_strobe_o,
  output logic             field_start_o,
  output logic             field_odd_o,
  output logic             interlaced_o,
  output logic [ROW_W-1:0] row_addr_o
);
  logic fall, act, broad, narrow;
  logic [CNT_W-1:0] fall_pos;

  cs_sync_edge #(.BROAD_MIN(BROAD_MIN)) u_edge (
    .clk_i, .rst_ni, .pix_en_i, .csync_i, .edge_sel_i,
    .fall_o(fall), .act_o(act), .broad_o(broad), .narrow_o(narrow)
  );

  cs_line_timer #(.LINE_LEN(LINE_LEN), .MASK_PIX(MASK_PIX), .CNT_W(CNT_W)) u_line (
    .clk_i, .rst_ni, .pix_en_i, .act_i(act), .fall_i(fall),
    .line_start_o, .pix_cnt_o, .fall_pos_o(fall_pos), .strobe_o(pix_strobe_o)
  );

  cs_field_track #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W), .ROW_W(ROW_W)) u_field (
    .clk_i, .rst_ni, .broad_i(broad), .narrow_i(narrow),
    .line_start_i(line_start_o), .fall_pos_i(fall_pos),
    .field_start_o, .field_odd_o, .interlaced_o, .row_o(row_addr_o)
  );
endmodule

// File: rtl/csync_weave_chk.sv
module csync_weave_chk #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned ROW_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_en_i,
  input logic             line_start_o,
  input logic [CNT_W-1:0] pix_cnt_o,
  input logic             pix_strobe_o,
  input logic             field_start_o,
  input logic             field_odd_o,
  input logic             interlaced_o,
  input logic [ROW_W-1:0] row_addr_o
);
  // R2
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> pix_cnt_o == CNT_W'(1));
  // R3
  strobe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !pix_strobe_o);
  // R3
  strobe_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_strobe_o |-> pix_en_i);
  // R4
  single_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_o |=> !field_start_o);
  // R9
  parity_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_odd_o) |-> field_start_o);
  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(interlaced_o) |-> field_start_o);
  // R7
  row_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interlaced_o |-> row_addr_o[0] == field_odd_o);
endmodule

bind csync_weave_tracker csync_weave_chk #(.CNT_W(CNT_W), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/tb_csync_weave_tracker.sv
module tb_csync_weave_tracker;
  localparam int L   = 64;
  localparam int HSW = 4;
  localparam int BW  = 24;
  localparam int CW  = $clog2(2 * L + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0, pix_en_i = 1'b1, csync_i = 1'b1, edge_sel_i = 1'b0;
  logic line_start_o, pix_strobe_o, field_start_o, field_odd_o, interlaced_o;
  logic [CW-1:0] pix_cnt_o;
  logic [9:0]    row_addr_o;

  int n_chk = 0, n_bad = 0;
  int ls_cnt, ls_idx, stb_low, fs_cnt, row_s, cnt_end;

  always #2.5 clk_i = ~clk_i;

  csync_weave_tracker #(.LINE_LEN(L), .BROAD_MIN(16), .MASK_PIX(2), .ROW_W(10)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic cs, input int idx);
    csync_i = cs;
    #1;
    if (line_start_o) begin ls_cnt++; ls_idx = idx; end
    if (!pix_strobe_o) stb_low++;
    if (field_start_o) fs_cnt++;
    if (idx == 10) row_s = int'(row_addr_o);
    if (idx == L - 1) cnt_end = int'(pix_cnt_o);
    @(posedge clk_i); #1;
  endtask

  task automatic clr();
    ls_cnt = 0; ls_idx = -1; stb_low = 0; fs_cnt = 0;
  endtask

  task automatic hline();
    clr();
    for (int i = 0; i < L; i++) step(i >= HSW, i);
  endtask

  task automatic vline(input bit odd);
    clr();
    for (int i = 0; i < L; i++) begin
      if (odd) step(!(i < HSW || (i >= L/2 && i < L/2 + BW)), i);
      else     step(i >= BW, i);
    end
  endtask

  task automatic run_field(input string nm, input bit odd, input int exp_int,
                           input int r0, input int stp, input bit rows);
    for (int k = 0; k < 2; k++) hline();
    vline(odd);
    check({"R4 field start ", nm}, fs_cnt, 1);
    check({"R5 parity ", nm}, int'(field_odd_o), int'(odd));
    check({"R6 mode ", nm}, int'(interlaced_o), exp_int);
    for (int k = 0; k < 3; k++) begin
      hline();
      if (rows) check({"R7 row ", nm}, row_s, r0 + k * stp);
    end
  endtask

  task automatic t_reset();
    #1;
    check("R8 odd", int'(field_odd_o), 0);
    check("R8 interlaced", int'(interlaced_o), 0);
    check("R8 row", int'(row_addr_o), 0);
    check("R8 count", int'(pix_cnt_o), 0);
    check("R8 strobe", int'(pix_strobe_o), 1);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R8 fstart", int'(field_start_o), 0);
  endtask

  task automatic t_lines();
    for (int k = 0; k < 3; k++) hline();
    check("R1 one start per line", ls_cnt, 1);
    check("R1 falling edge pos", ls_idx, 0);
    check("R3 gated pixels", stb_low, 3);
    check("R2 count at line end", cnt_end, L - 1);
  endtask

  task automatic t_gap();
    int c0;
    clr();
    for (int i = 0; i < 20; i++) step(i >= HSW, i);
    pix_en_i = 1'b0;
    c0 = int'(pix_cnt_o);
    #1;
    check("R3 strobe off without enable", int'(pix_strobe_o), 0);
    @(posedge clk_i); #1;
    check("R2 count holds", int'(pix_cnt_o), c0);
    pix_en_i = 1'b1;
    for (int i = 20; i < L; i++) step(1'b1, i);
  endtask

  task automatic t_rise();
    edge_sel_i = 1'b1;
    hline(); hline();
    check("R1 rising edge pos", ls_idx, HSW);
    check("R1 rising one start", ls_cnt, 1);
    run_field("rise odd", 1'b1, 0, 0, 1, 1'b0);
    run_field("rise even", 1'b0, 1, 0, 2, 1'b0);
    edge_sel_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_lines();
    t_gap();
    run_field("first even", 1'b0, 0, 0, 1, 1'b1);
    run_field("second even", 1'b0, 0, 0, 1, 1'b1);
    run_field("odd after even", 1'b1, 1, 1, 2, 1'b1);
    run_field("even after odd", 1'b0, 1, 0, 2, 1'b1);
    run_field("odd again", 1'b1, 1, 1, 2, 1'b1);
    run_field("odd repeat", 1'b1, 0, 0, 1, 1'b1);
    t_rise();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule